// File: doc/BRIEF.md
# Compare-Match Timer Output Unit

This block is an up-counting timer with two comparators and one output pin. It counts a free-running clock-enable tick while a run bit is set. Comparator A matches the full count against a programmable register. Comparator P matches the count against a coarse period register that covers only the top bits of the counter. A clear-select bit decides which comparator ends the count period. Each comparator sets its own sticky request flag, and software clears each flag with a write-one strobe.

The output pin reacts only to comparator A events. A two-bit action field picks one of four responses: leave the pin alone, drive it low, drive it high, or toggle it. Each time the run bit goes from low to high, the pin takes its starting level from an init control bit. This lets the pin be set up before the timer starts running.

Top module: `cmp_timer`

## Requirements
- R1: The counter advances by one on each clock where `tick` and `run_en` are both high. Otherwise it holds its value, and the pin holds its value too.
- R2: With `clr_sel`=0 and `cmp_p`=p≠0, the counter returns to 0 on the tick taken at count p·128−1, so the period is p·128 ticks. `flag_p` sets on that same tick.
- R3: With `clr_sel`=0 and `cmp_p`=0, the counter runs up to 1023 and wraps to 0. `flag_p` sets on the wrapping tick.
- R4: With `clr_sel`=0, a tick taken at count == `cmp_a` sets `flag_a` and applies the pin action. It does not clear the counter.
- R5: With `clr_sel`=1, the counter returns to 0 on the tick taken at count == `cmp_a`, so the period is `cmp_a`+1 ticks. `flag_a` sets on that tick, and `flag_p` never sets whatever the value of `cmp_p`.
- R6: A `cmp_a` value of 0 is invalid. It produces no A match, no `flag_a` and no pin action, so with `clr_sel`=1 the counter wraps at 1023.
- R7: On an A match, `pin_act` selects the pin response: 00 = unchanged, 01 = drive 0, 10 = drive 1, 11 = invert.
- R8: P-comparator events never change `pin_out`.
- R9: On the first clock where `run_en` is high after being low, `pin_out` loads `pin_init`. This load takes priority over an A-match action on the same clock.
- R10: The flags are sticky until `ack_a` or `ack_p` is pulsed high for one clock. A set event and an ack on the same clock leave the flag set.
- R11: After reset, `count`, `flag_a`, `flag_p` and `pin_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable pulse |
| run_en | input | 1 | Timer run bit |
| clr_sel | input | 1 | Clear source: 0 = comparator P, 1 = comparator A |
| pin_act | input | 2 | Pin action on A match |
| pin_init | input | 1 | Pin level loaded when `run_en` rises |
| cmp_a | input | 10 | Comparator A value (0 invalid) |
| cmp_p | input | 3 | Comparator P value against count bits 9:7 |
| ack_a | input | 1 | Write-one clear of `flag_a` |
| ack_p | input | 1 | Write-one clear of `flag_p` |
| flag_a | output | 1 | Comparator A request flag |
| flag_p | output | 1 | Comparator P request flag |
| pin_out | output | 1 | Timer output pin |
| count | output | 10 | Current count value |

## Verification
Every result is due exactly one clock after the tick that causes it. After n ticks from 0 the count reads n. A match on the tick taken at count k shows up, together with its clear, its flag and its pin change, one clock after that tick. An ack or a `run_en` rise takes effect on the next clock. The bench drives inputs and samples outputs at falling edges, so each check reads the value registered at the rising edge just before. The expected counts are derived from the number of ticks applied, using the period formulas stated in the requirements.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } pin_act_e;

endpackage

// File: rtl/cmp_timer_match.sv
module cmp_timer_match #(
    parameter int CNT_W = 10,
    parameter int PER_W = 3
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [PER_W-1:0] cmp_p,
    output logic             a_hit,
    output logic             p_hit
);
    localparam int LOW_W = CNT_W - PER_W;

    logic [PER_W-1:0] p_top;

    always_comb begin
        // last count of the period: top bits equal p-1 (p=0 wraps to all ones), low bits all ones
        p_top = cmp_p - PER_W'(1);
        p_hit = (cnt[CNT_W-1:LOW_W] == p_top) && (&cnt[LOW_W-1:0]);
        a_hit = (cmp_a != '0) && (cnt == cmp_a);
    end

    always_comb begin
        assert_zero_a_R6: assert (!(cmp_a == '0 && a_hit));
    end
endmodule

// File: rtl/cmp_timer_pin.sv
module cmp_timer_pin
    import cmp_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_rise,
    input  logic       a_evt,
    input  logic [1:0] act,
    input  logic       init,
    output logic       pin
);
    typedef struct packed {
        logic pin;
    } pin_st_t;

    pin_st_t st_d, st_q;
    pin_act_e act_e;

    always_comb begin
        act_e = pin_act_e'(act);
        st_d  = st_q;
        if (en_rise) begin
            st_d.pin = init;
        end else if (a_evt) begin
            case (act_e)
                ACT_LOW:    st_d.pin = 1'b0;
                ACT_HIGH:   st_d.pin = 1'b1;
                ACT_TOGGLE: st_d.pin = ~st_q.pin;
                default:    st_d.pin = st_q.pin;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin = st_q.pin;

    assert_pin_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_evt && !en_rise) |=> $stable(pin));

    assert_none_act_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_evt && !en_rise && act == 2'b00) |=> $stable(pin));

    assert_init_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> (pin == $past(init)));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
    parameter int CNT_W = 10,
    parameter int PER_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run_en,
    input  logic             clr_sel,
    input  logic [1:0]       pin_act,
    input  logic             pin_init,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [PER_W-1:0] cmp_p,
    input  logic             ack_a,
    input  logic             ack_p,
    output logic             flag_a,
    output logic             flag_p,
    output logic             pin_out,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fa;
        logic             fp;
        logic             en;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic a_hit, p_hit;
    logic step, a_evt, p_evt, clear, en_rise;

    cmp_timer_match #(.CNT_W(CNT_W), .PER_W(PER_W)) i_match (
        .cnt   (st_q.cnt),
        .cmp_a (cmp_a),
        .cmp_p (cmp_p),
        .a_hit (a_hit),
        .p_hit (p_hit)
    );

    always_comb begin
        step    = tick && run_en;
        a_evt   = step && a_hit;
        p_evt   = step && p_hit && !clr_sel;
        clear   = clr_sel ? a_evt : p_evt;
        en_rise = run_en && !st_q.en;

        st_d    = st_q;
        st_d.en = run_en;
        if (step) st_d.cnt = clear ? '0 : st_q.cnt + CNT_W'(1);
        st_d.fa = a_evt || (st_q.fa && !ack_a);
        st_d.fp = p_evt || (st_q.fp && !ack_p);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    cmp_timer_pin i_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_rise (en_rise),
        .a_evt   (a_evt),
        .act     (pin_act),
        .init    (pin_init),
        .pin     (pin_out)
    );

    assign count  = st_q.cnt;
    assign flag_a = st_q.fa;
    assign flag_p = st_q.fp;

    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && run_en) |=> $stable(count));

    assert_a_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sel && tick && run_en && a_hit) |=> (count == '0 && flag_a));

    assert_no_p_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sel && !flag_p) |=> !flag_p);

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_a && !ack_a) |=> flag_a);

    assert_a_no_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_sel && tick && run_en && a_hit && !p_hit) |=> (count != '0 && flag_a));
endmodule

// File: tb/test_cmp_timer.sv
module test_cmp_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n, tick, run_en, clr_sel, pin_init, ack_a, ack_p;
    logic [1:0] pin_act;
    logic [9:0] cmp_a;
    logic [2:0] cmp_p;
    logic       flag_a, flag_p, pin_out;
    logic [9:0] count;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_timer i_cmp_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run_en(run_en), .clr_sel(clr_sel),
        .pin_act(pin_act), .pin_init(pin_init), .cmp_a(cmp_a), .cmp_p(cmp_p),
        .ack_a(ack_a), .ack_p(ack_p), .flag_a(flag_a), .flag_p(flag_p),
        .pin_out(pin_out), .count(count)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick = 1'b0; run_en = 1'b0; clr_sel = 1'b0; pin_init = 1'b0;
        ack_a = 1'b0; ack_p = 1'b0; pin_act = 2'b00; cmp_a = '0; cmp_p = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R11 reset state
        do_reset();
        check("R11 count", count, 0);
        check("R11 flag_a", flag_a, 0);
        check("R11 flag_p", flag_p, 0);
        check("R11 pin", pin_out, 0);

        // R1 counting gated by tick and run_en
        do_reset();
        clr_sel = 1'b1; cmp_a = 10'd6; pin_act = 2'b10; run_en = 1'b1;
        ticks(5);
        check("R1 count after 5", count, 5);
        repeat (3) @(negedge clk);
        check("R1 hold without tick", count, 5);
        run_en = 1'b0;
        ticks(4);
        check("R1 hold when disabled", count, 5);
        check("R1 pin held when disabled", pin_out, 0);
        run_en = 1'b1;
        ticks(1);
        check("R1 count resumes", count, 6);
        ticks(1);
        check("R1 wrap at A", count, 0);
        check("R1 pin driven", pin_out, 1);
        for (int i = 0; i < 6; i++) begin
            tick = (i % 2 == 0);
            @(negedge clk);
        end
        tick = 1'b0;
        check("R1 alternating tick", count, 3);

        // R5 sweep of A with clear on A, toggle action
        for (int a = 1; a <= 42; a++) begin
            int av;
            av = (a == 41) ? 511 : (a == 42) ? 1023 : a;
            do_reset();
            clr_sel = 1'b1; cmp_a = 10'(av); cmp_p = 3'd1; pin_act = 2'b11; run_en = 1'b1;
            ticks(av);
            check("R5 count at A", count, av);
            check("R5 flag_a before match", flag_a, 0);
            ticks(1);
            check("R5 cleared", count, 0);
            check("R5 flag_a set", flag_a, 1);
            check("R7 toggle up", pin_out, 1);
            ack_a = 1'b1; @(negedge clk); ack_a = 1'b0;
            check("R10 ack clears", flag_a, 0);
            ticks(av + 1);
            check("R5 second period", count, 0);
            check("R5 flag_a again", flag_a, 1);
            check("R7 toggle down", pin_out, 0);
            check("R5 flag_p suppressed", flag_p, 0);
        end

        // R2 / R3 sweep of P with clear on P, no A
        for (int p = 0; p < 8; p++) begin
            int per;
            string tg;
            per = ((p == 0) ? 8 : p) * 128;
            tg  = (p == 0) ? "R3" : "R2";
            do_reset();
            clr_sel = 1'b0; cmp_a = '0; cmp_p = 3'(p); pin_act = 2'b11; pin_init = 1'b1; run_en = 1'b1;
            ticks(per - 1);
            check({tg, " count at end"}, count, per - 1);
            check({tg, " flag_p before"}, flag_p, 0);
            ticks(1);
            check({tg, " cleared"}, count, 0);
            check({tg, " flag_p set"}, flag_p, 1);
            check("R8 pin unaffected", pin_out, 1);
            check("R6 flag_a none", flag_a, 0);
        end

        // R4 A match without clear when P selects the period
        do_reset();
        clr_sel = 1'b0; cmp_p = 3'd2; cmp_a = 10'd100; pin_act = 2'b10; run_en = 1'b1;
        ticks(100);
        check("R4 count at A", count, 100);
        check("R4 pin before", pin_out, 0);
        ticks(1);
        check("R4 no clear", count, 101);
        check("R4 flag_a", flag_a, 1);
        check("R4 pin high", pin_out, 1);
        ticks(154);
        check("R4 flag_p before", flag_p, 0);
        ticks(1);
        check("R2 clear at 256", count, 0);
        check("R2 flag_p", flag_p, 1);
        check("R8 pin kept", pin_out, 1);
        ack_p = 1'b1; @(negedge clk); ack_p = 1'b0;
        check("R10 ack_p clears", flag_p, 0);

        // R6 A of zero with clear on A
        do_reset();
        clr_sel = 1'b1; cmp_a = '0; pin_act = 2'b11; pin_init = 1'b1; run_en = 1'b1;
        ticks(1023);
        check("R6 count 1023", count, 1023);
        ticks(1);
        check("R6 wrap", count, 0);
        check("R6 no flag_a", flag_a, 0);
        check("R6 pin unchanged", pin_out, 1);
        check("R5 no flag_p", flag_p, 0);

        // R7 all action codes with both init levels
        for (int ac = 0; ac < 4; ac++) begin
            for (int in = 0; in < 2; in++) begin
                int ex;
                ex = (ac == 0) ? in : (ac == 1) ? 0 : (ac == 2) ? 1 : 1 - in;
                do_reset();
                clr_sel = 1'b1; cmp_a = 10'd3; pin_act = 2'(ac); pin_init = 1'(in); run_en = 1'b1;
                ticks(3);
                check("R9 init loaded", pin_out, in);
                ticks(1);
                check("R7 action", pin_out, ex);
            end
        end

        // R10 set beats ack; sticky otherwise
        do_reset();
        clr_sel = 1'b1; cmp_a = 10'd3; run_en = 1'b1;
        ticks(3);
        ack_a = 1'b1;
        ticks(1);
        ack_a = 1'b0;
        check("R10 set wins", flag_a, 1);
        ticks(2);
        check("R10 sticky", flag_a, 1);
        ack_a = 1'b1; @(negedge clk); ack_a = 1'b0;
        check("R10 ack", flag_a, 0);
        ticks(1);
        check("R10 stays clear", flag_a, 0);

        // R9 enable rise loads init, wins over A action
        do_reset();
        pin_init = 1'b1; run_en = 1'b1;
        @(negedge clk);
        check("R9 load 1", pin_out, 1);
        run_en = 1'b0; pin_init = 1'b0;
        @(negedge clk);
        check("R9 no load while low", pin_out, 1);
        run_en = 1'b1;
        @(negedge clk);
        check("R9 load 0", pin_out, 0);
        clr_sel = 1'b1; cmp_a = 10'd2;
        ticks(2);
        check("R9 count at A", count, 2);
        run_en = 1'b0; pin_act = 2'b10;
        @(negedge clk);
        run_en = 1'b1;
        ticks(1);
        check("R9 match taken", count, 0);
        check("R9 flag_a", flag_a, 1);
        check("R9 init wins", pin_out, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule